// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers 72 level-sensitive interrupt lines into three groups and drives one interrupt request to a processor. Two wide groups carry 32 peripheral lines each; a narrow basic group carries 8 local lines. Every line has an enable bit. Software never writes an enable word directly. It writes a mask to a per-group set register or a per-group clear register, and only the bits written as 1 change.

A line counts as pending while its input is high and its enable is set. Pending is not latched, so a bit falls as soon as the line falls. Software reads the enabled pending state of each wide group from its own register. A summary word lets software avoid most of those reads: it carries the basic lines directly, one "something pending" flag per wide group, and copies of a few chosen lines from each wide group. Register access goes through a plain 32-bit read/write port with a word address. The request output is registered.

Top module: `banked_irq_ctrl`

## Requirements
- R1: During and after reset every enable is clear, `irqOut` is low and `busRdData` is zero.
- R2: A write to the set register of a group (word 4 for the basic group, 5 for wide group 1, 6 for wide group 2) sets each enable whose data bit is 1 and leaves the others unchanged. For the basic group only data bits 7:0 are used.
- R3: A write to the clear register of a group (word 8 basic, 9 wide group 1, 10 wide group 2) clears each enable whose data bit is 1 and leaves the others unchanged.
- R4: Reading either the set or the clear word of a group returns that group's current enable mask. For the basic group the mask sits in bits 7:0 and bits 31:8 read zero.
- R5: Word 1 reads wide group 1 and word 2 reads wide group 2, as input AND enable. The bit follows the input level with no latching.
- R6: Summary word 0, bits 7:0, hold basic line n AND its enable in bit n.
- R7: Summary bit 8 is high when any enabled line of wide group 1 is high. Summary bit 9 does the same for wide group 2.
- R8: Summary bits 10..14 copy the enabled pending state of wide-group-1 lines 7, 9, 10, 18 and 19, in that order. Bits 15..20 copy wide-group-2 lines 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read zero.
- R9: `irqOut` is the OR of every enabled high line across all groups. It is registered, so it reflects the inputs and enables of the previous cycle.
- R10: Writes to words 0, 1, 2, 3, 7, 11 and 12..15 change no enable. Words 3, 7, 11 and 12..15 read zero. Words 7 and 11 are the set and clear slots of the unused group number 3.
- R11: Read data appears on `busRdData` in the cycle after `busRdEn` is high and shows the state just before that clock edge, so a write in the same cycle is not yet visible. In any cycle after one with `busRdEn` low, `busRdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcBasic | input | 8 | Basic group level inputs |
| srcBank1 | input | 32 | Wide group 1 level inputs |
| srcBank2 | input | 32 | Wide group 2 level inputs |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 4 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the read strobe |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Two functions can land in the same cycle: an enable update through a set or clear strobe, and a change on a source line that reaches the request output and the pending views. The bench provokes this by raising lines while clearing or setting their enables, and by reading a pending or enable word in the same cycle as a write to it. It then holds these against a behavioural model that applies each write only after it has sampled the read and request values. A long random phase then mixes reads, writes to every word and toggling inputs on every cycle, and the model compares `busRdData` and `irqOut` at each clock.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

  localparam int BANK_W  = 32;
  localparam int BASIC_W = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int N_GRP   = 3;

  // word offsets; group number is added to the set/clear bases
  localparam logic [ADDR_W-1:0] OFF_SUMMARY  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_PEND1    = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_PEND2    = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_SET_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_CLR_BASE = 4'd8;

  // summary layout
  localparam int SUM_ANY1  = BASIC_W;
  localparam int SUM_ANY2  = BASIC_W + 1;
  localparam int SC1_N     = 5;
  localparam int SC2_N     = 6;
  localparam int SUM_SC1_LO = SUM_ANY2 + 1;
  localparam int SUM_SC2_LO = SUM_SC1_LO + SC1_N;

  localparam int SC1_IDX [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_IDX [SC2_N] = '{21, 22, 23, 24, 25, 30};

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SUMMARY,
    RD_PEND1,
    RD_PEND2,
    RD_ENABLE
  } rdSel_e;

  typedef struct packed {
    logic [N_GRP-1:0] setStb;
    logic [N_GRP-1:0] clrStb;
    logic             rdStb;
    rdSel_e           rdSel;
    logic [1:0]       rdGrp;
  } ctrlStb_t;

endpackage

// File: rtl/banked_irq_control.sv
module banked_irq_control
  import banked_irq_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb
);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    for (int g = 0; g < N_GRP; g++) begin
      stb.setStb[g] = busWrEn && (busAddr == OFF_SET_BASE + ADDR_W'(g));
      stb.clrStb[g] = busWrEn && (busAddr == OFF_CLR_BASE + ADDR_W'(g));
    end
    stb.rdStb = busRdEn;
    if (busRdEn) begin
      if (busAddr == OFF_SUMMARY)      stb.rdSel = RD_SUMMARY;
      else if (busAddr == OFF_PEND1)   stb.rdSel = RD_PEND1;
      else if (busAddr == OFF_PEND2)   stb.rdSel = RD_PEND2;
      for (int g = 0; g < N_GRP; g++) begin
        if (busAddr == OFF_SET_BASE + ADDR_W'(g) ||
            busAddr == OFF_CLR_BASE + ADDR_W'(g)) begin
          stb.rdSel = RD_ENABLE;
          stb.rdGrp = 2'(g);
        end
      end
    end
  end

endmodule

// File: rtl/banked_irq_datapath.sv
module banked_irq_datapath
  import banked_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BASIC_W-1:0] srcBasic,
  input  logic [BANK_W-1:0]  srcBank1,
  input  logic [BANK_W-1:0]  srcBank2,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [BASIC_W-1:0] enBasic,
  output logic [BANK_W-1:0]  enBank1,
  output logic [BANK_W-1:0]  enBank2
);

  logic [BANK_W-1:0] srcAll  [N_GRP];
  logic [BANK_W-1:0] enAll   [N_GRP];
  logic [BANK_W-1:0] pendAll [N_GRP];

  assign srcAll[0] = BANK_W'(srcBasic);
  assign srcAll[1] = srcBank1;
  assign srcAll[2] = srcBank2;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int W = (g == 0) ? BASIC_W : BANK_W;
    localparam logic [BANK_W-1:0] KEEP = BANK_W'((65'd1 << W) - 65'd1);
    logic [BANK_W-1:0] enQ;
    logic [BANK_W-1:0] wrMask;

    assign wrMask = BANK_W'(wrData) & KEEP;

    always_ff @(posedge clk) begin
      if (!rstN)                enQ <= '0;
      else if (stb.setStb[g])   enQ <= enQ | wrMask;
      else if (stb.clrStb[g])   enQ <= enQ & ~wrMask;
    end

    assign enAll[g]   = enQ;
    assign pendAll[g] = srcAll[g] & enQ;
  end

  assign enBasic = enAll[0][BASIC_W-1:0];
  assign enBank1 = enAll[1];
  assign enBank2 = enAll[2];

  logic [DATA_W-1:0] summary;
  always_comb begin
    summary = '0;
    summary[BASIC_W-1:0] = pendAll[0][BASIC_W-1:0];
    summary[SUM_ANY1]    = |pendAll[1];
    summary[SUM_ANY2]    = |pendAll[2];
    for (int i = 0; i < SC1_N; i++) summary[SUM_SC1_LO + i] = pendAll[1][SC1_IDX[i]];
    for (int i = 0; i < SC2_N; i++) summary[SUM_SC2_LO + i] = pendAll[2][SC2_IDX[i]];
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_SUMMARY: rdNext = summary;
      RD_PEND1:   rdNext = DATA_W'(pendAll[1]);
      RD_PEND2:   rdNext = DATA_W'(pendAll[2]);
      RD_ENABLE: begin
        case (stb.rdGrp)
          2'd0:    rdNext = DATA_W'(enAll[0]);
          2'd1:    rdNext = DATA_W'(enAll[1]);
          2'd2:    rdNext = DATA_W'(enAll[2]);
          default: rdNext = '0;
        endcase
      end
      default:    rdNext = '0;
    endcase
  end

  logic anyPend;
  always_comb begin
    anyPend = 1'b0;
    for (int g = 0; g < N_GRP; g++) anyPend = anyPend | (|pendAll[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irq    <= 1'b0;
    end else begin
      rdData <= stb.rdStb ? rdNext : '0;
      irq    <= anyPend;
    end
  end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BASIC_W-1:0] srcBasic,
  input  logic [BANK_W-1:0]  srcBank1,
  input  logic [BANK_W-1:0]  srcBank2,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);

  ctrlStb_t           stb;
  logic [BASIC_W-1:0] enBasic;
  logic [BANK_W-1:0]  enBank1;
  logic [BANK_W-1:0]  enBank2;

  banked_irq_control u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  banked_irq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (busWrData),
    .srcBasic (srcBasic),
    .srcBank1 (srcBank1),
    .srcBank2 (srcBank2),
    .rdData   (busRdData),
    .irq      (irqOut),
    .enBasic  (enBasic),
    .enBank1  (enBank1),
    .enBank2  (enBank2)
  );

endmodule

// File: rtl/banked_irq_chk.sv
module banked_irq_chk
  import banked_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [BASIC_W-1:0] srcBasic,
  input logic [BANK_W-1:0]  srcBank1,
  input logic [BANK_W-1:0]  srcBank2,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [DATA_W-1:0]  busRdData,
  input logic               irqOut,
  input logic [BASIC_W-1:0] enBasic,
  input logic [BANK_W-1:0]  enBank1,
  input logic [BANK_W-1:0]  enBank2
);

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past((|(srcBasic & enBasic)) | (|(srcBank1 & enBank1)) | (|(srcBank2 & enBank2)))); // R9

  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'd5) |=> ((enBank1 & $past(busWrData)) == $past(busWrData))); // R2

  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'd10) |=> ((enBank2 & $past(busWrData)) == '0)); // R3

  AST_BAD_GROUP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == 4'd7 || busAddr == 4'd11 || busAddr < 4'd4)) |=>
      ($stable(enBasic) && $stable(enBank1) && $stable(enBank2))); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == '0); // R11

  AST_SUMMARY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 4'd0) |=> busRdData[31:21] == '0); // R8

endmodule

bind banked_irq_ctrl banked_irq_chk u_chk (.*);

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  srcBasic;
  logic [31:0] srcBank1, srcBank2;
  logic        busWrEn, busRdEn;
  logic [3:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        irqOut;

  always #2 clk = ~clk;

  banked_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .srcBasic(srcBasic), .srcBank1(srcBank1),
    .srcBank2(srcBank2), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] mEn [3];
  logic [31:0] expRd;
  logic        expIrq;
  bit          lastRd;
  int          lastAddr;
  bit          inReset;
  int sc1[$] = '{7, 9, 10, 18, 19};
  int sc2[$] = '{21, 22, 23, 24, 25, 30};

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] p0, p1, p2, r;
    p0 = {24'b0, srcBasic} & mEn[0];
    p1 = srcBank1 & mEn[1];
    p2 = srcBank2 & mEn[2];
    r = 32'b0;
    case (a)
      0: begin
        r[7:0] = p0[7:0];
        r[8] = |p1;
        r[9] = |p2;
        foreach (sc1[i]) r[10 + i] = p1[sc1[i]];
        foreach (sc2[i]) r[15 + i] = p2[sc2[i]];
      end
      1: r = p1;
      2: r = p2;
      4, 8:  r = mEn[0];
      5, 9:  r = mEn[1];
      6, 10: r = mEn[2];
      default: r = 32'b0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      for (int g = 0; g < 3; g++) mEn[g] = 32'b0;
      expRd = 32'b0; expIrq = 1'b0; lastRd = 0; inReset = 1;
    end else begin
      inReset = 0;
      expIrq = (|({24'b0, srcBasic} & mEn[0])) | (|(srcBank1 & mEn[1])) | (|(srcBank2 & mEn[2]));
      expRd = busRdEn ? modelRead(int'(busAddr)) : 32'b0;
      lastRd = busRdEn;
      lastAddr = int'(busAddr);
      if (busWrEn) begin
        case (int'(busAddr))
          4:  mEn[0] = mEn[0] | (busWrData & 32'hFF);
          5:  mEn[1] = mEn[1] | busWrData;
          6:  mEn[2] = mEn[2] | busWrData;
          8:  mEn[0] = mEn[0] & ~busWrData;
          9:  mEn[1] = mEn[1] & ~busWrData;
          10: mEn[2] = mEn[2] & ~busWrData;
          default: ;
        endcase
      end
    end
  end

  function automatic string tagFor();
    if (inReset) return "R1";
    if (!lastRd) return "R11";
    case (lastAddr)
      0: return "R6 R7 R8";
      1, 2: return "R5";
      4, 5, 6: return "R2 R4";
      8, 9, 10: return "R3 R4";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (busRdData !== expRd) begin
        failures++;
        $display("FAIL %s busRdData addr=%0d actual=%h expected=%h", tagFor(), lastAddr, busRdData, expRd);
      end
      checks++;
      if (irqOut !== expIrq) begin
        failures++;
        $display("FAIL %s irqOut actual=%0b expected=%0b", inReset ? "R1" : "R9", irqOut, expIrq);
      end
    end
  end

  task automatic idle();
    busWrEn = 0; busRdEn = 0;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    busWrEn = 1; busRdEn = 0; busAddr = 4'(a); busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(int a);
    busWrEn = 0; busRdEn = 1; busAddr = 4'(a);
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic rdwr(int a, logic [31:0] d);
    busWrEn = 1; busRdEn = 1; busAddr = 4'(a); busWrData = d;
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
  endtask

  initial begin
    rstN = 0; srcBasic = '0; srcBank1 = '0; srcBank2 = '0;
    busWrEn = 0; busRdEn = 0; busAddr = '0; busWrData = '0;
    repeat (4) @(negedge clk);
    // R1: lines high during reset must not raise the request
    srcBank1 = 32'hFFFF_FFFF;
    @(negedge clk);
    rstN = 1;
    for (int a = 0; a < 16; a++) rd(a);          // R1 R10 read-back after reset
    srcBasic = 8'hFF; srcBank2 = 32'hFFFF_FFFF;
    idle(); idle();                               // R9 no enables, no request
    // R2 basic ignores upper data bits
    wr(4, 32'hFFFF_FF5A); rd(4); rd(8); rd(0); idle();
    // R2 wide group 1 incl. shortcut lines
    srcBank1 = 32'h0000_0000;
    wr(5, 32'h000C_0681); rd(5); rd(1); rd(0);
    srcBank1 = 32'h000C_0680; rd(1); rd(0);        // R5 R8
    srcBank1 = 32'h0000_0080; rd(1); rd(0);        // R5 level follows input
    // R3 wide group 2
    wr(6, 32'hFFFF_FFFF); wr(10, 32'h0F0F_0F0F); rd(6); rd(10); rd(2); rd(0);
    // R10 writes to read-only and unused words
    for (int a = 0; a < 16; a++) begin
      if (!(a >= 4 && a <= 6) && !(a >= 8 && a <= 10)) wr(a, 32'hFFFF_FFFF);
    end
    for (int a = 0; a < 16; a++) rd(a);
    // simultaneous: line rises while its enable is cleared; read during write
    srcBasic = 8'h00; srcBank1 = 32'h0; srcBank2 = 32'h0;
    idle();
    busWrEn = 1; busAddr = 4'd9; busWrData = 32'hFFFF_FFFF; srcBank1 = 32'h0000_0400;
    @(negedge clk); busWrEn = 0;
    idle();
    wr(5, 32'h0000_0400); idle();                 // R9 request rises
    rdwr(9, 32'h0000_0400); rd(9);                // R11 old value, then new
    srcBank2 = 32'h4000_0000; rdwr(6, 32'h4000_0000); rd(0); idle();
    rdwr(10, 32'hFFFF_FFFF); rd(2); idle();
    wr(8, 32'hFF); wr(9, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF); idle(); idle();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      busWrEn   = ($urandom_range(0, 2) == 0);
      busRdEn   = ($urandom_range(0, 1) == 0);
      busAddr   = 4'($urandom_range(0, 15));
      busWrData = $urandom();
      if ($urandom_range(0, 3) == 0) busWrData = busWrData & $urandom();
      if ($urandom_range(0, 2) == 0) srcBasic = 8'($urandom());
      if ($urandom_range(0, 2) == 0) srcBank1 = $urandom() & $urandom();
      if ($urandom_range(0, 2) == 0) srcBank2 = $urandom() & $urandom();
      @(negedge clk);
    end
    idle();
    // reset again mid-run with enables set
    rstN = 0; idle(); idle(); rstN = 1;
    for (int a = 4; a < 7; a++) rd(a);
    idle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule